// File: doc/BRIEF.md
# Accumulator Machine Core

This block is a complete processor core for a minimal 32-bit accumulator machine. It contains a 32-word by 32-bit store and has one instruction format. The core keeps three registers: a 5-bit current-instruction counter, a present-instruction register and an accumulator. All three are brought out to ports for debug.

Every instruction takes two clock cycles. First the counter is advanced and the word it now points at is fetched. Then that word is executed. Operand values always come from the store, and the two jump forms also take their target from a store word rather than from the instruction. A host loads programs and data, and reads back results, through a deposit/examine port that works only while the core is halted.

The core is controlled by a state machine with three states:

- `ST_HALT` is the idle state, and host access is allowed in it.
- `ST_FETCH` advances the counter and loads the present instruction.
- `ST_EXEC` executes the decoded operation.

The transitions are:

- `ST_HALT` to `ST_FETCH` when run or step is requested.
- `ST_FETCH` to `ST_EXEC` unconditionally.
- `ST_EXEC` to `ST_FETCH` while running freely.
- `ST_EXEC` to `ST_HALT` on a stop operation or at the end of a single step.

Top module: `acc_core`

## Requirements
- R1: Reset sets halted_o to 1 and clears ci_o, acc_o and pi_o to zero.
- R2: While halted, host_we_i writes host_wdata_i into word host_addr_i at the next clock edge. host_rdata_o always shows word host_addr_i while halted. A host write made while the core is running is ignored.
- R3: A one-cycle pulse on run_i while halted starts free running. Each instruction first sets the counter to (counter+1) mod 32. It then loads the store word at that address into pi_o and executes it. The first instruction after a start therefore comes from counter+1. While halted with no request, the counter and accumulator hold their values.
- R4: The operand address n is instruction bits 4:0, and the opcode is bits 15:13, with bit 0 the least significant. Every other bit of the instruction has no effect.
- R5: Opcode 000 sets the counter to the low 5 bits of store word n.
- R6: Opcode 001 adds the low 5 bits of store word n to the counter, modulo 32.
- R7: Opcode 010 loads the accumulator with the two's-complement negation of word n. Opcode 011 writes the accumulator into word n.
- R8: Opcode 100 subtracts word n from the accumulator, modulo 2^32. Opcode 101 behaves identically.
- R9: Opcode 110 adds one to the counter when accumulator bit 31 is set. Otherwise it changes nothing.
- R10: Opcode 111 enters the halted state with the counter left at the address of the stop word. A later start continues from the following word.
- R11: A one-cycle pulse on step_i while halted, with run_i low, executes exactly one instruction and then returns to halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Start free running (sampled while halted) |
| step_i | input | 1 | Execute one instruction (sampled while halted) |
| halted_o | output | 1 | Core is idle in the halted state |
| host_we_i | input | 1 | Host deposit strobe |
| host_addr_i | input | 5 | Host store address |
| host_wdata_i | input | 32 | Host deposit data |
| host_rdata_o | output | 32 | Host examine data (valid while halted) |
| ci_o | output | 5 | Current-instruction counter |
| pi_o | output | 32 | Present instruction |
| acc_o | output | 32 | Accumulator |

## Verification
The bench first fills all 32 words through the host port and reads them back. Next it sweeps subtraction chains over zero, the most negative value, all-ones and mixed words, with the negated load and both subtract opcodes in every chain. This separates opcode 101 from opcode 100, and it separates true negation from a plain load. In alternate runs, all ignored instruction bits are set to ones.

A second sweep gives the skip a set of accumulator values on both sides of the sign boundary, 0x80000000 included. Whether the guarded store happens shows whether the sign test is right. Jump targets carry garbage in their upper bits to show the 5-bit truncation. Single steps, and a host write attempted mid-run, confirm that exactly one instruction executes per step and that the store is protected while the core runs.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } state_t;

    typedef enum logic [2:0] {
        OP_JMP  = 3'd0,
        OP_JRL  = 3'd1,
        OP_LDN  = 3'd2,
        OP_STO  = 3'd3,
        OP_SUB  = 3'd4,
        OP_SUBX = 3'd5,
        OP_SKN  = 3'd6,
        OP_STP  = 3'd7
    } op_t;

endpackage

// File: rtl/acc_store.sv
module acc_store #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/acc_exec.sv
module acc_exec
    import acc_core_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  op_t               op,
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] acc,
    input  logic [ADDR_W-1:0] ci,
    output logic [WORD_W-1:0] acc_nxt,
    output logic [ADDR_W-1:0] ci_nxt,
    output logic              st_we,
    output logic              stop
);
    always_comb begin
        acc_nxt = acc;
        ci_nxt  = ci;
        st_we   = 1'b0;
        stop    = 1'b0;
        unique case (op)
            OP_JMP:  ci_nxt  = operand[ADDR_W-1:0];
            OP_JRL:  ci_nxt  = ci + operand[ADDR_W-1:0];
            OP_LDN:  acc_nxt = -operand;
            OP_STO:  st_we   = 1'b1;
            OP_SUB,
            OP_SUBX: acc_nxt = acc - operand;
            OP_SKN:  if (acc[WORD_W-1]) ci_nxt = ci + 1'b1;
            OP_STP:  stop    = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5,
    parameter int OP_LSB = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              step_i,
    output logic              halted_o,
    input  logic              host_we_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [WORD_W-1:0] host_wdata_i,
    output logic [WORD_W-1:0] host_rdata_o,
    output logic [ADDR_W-1:0] ci_o,
    output logic [WORD_W-1:0] pi_o,
    output logic [WORD_W-1:0] acc_o
);
    localparam int OP_W = 3;

    state_t            state_q, state_d;
    logic [ADDR_W-1:0] ci_q;
    logic [WORD_W-1:0] pi_q;
    logic [WORD_W-1:0] acc_q;
    logic              step_mode_q;

    logic [ADDR_W-1:0] ci_inc;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;
    op_t               op_w;
    logic [WORD_W-1:0] acc_nxt;
    logic [ADDR_W-1:0] ci_nxt;
    logic              ex_st_we;
    logic              ex_stop;

    assign ci_inc = ci_q + 1'b1;
    assign op_w   = op_t'(pi_q[OP_LSB +: OP_W]);

    always_comb begin
        unique case (state_q)
            ST_FETCH: rd_addr = ci_inc;
            ST_EXEC:  rd_addr = pi_q[ADDR_W-1:0];
            default:  rd_addr = host_addr_i;
        endcase
    end

    assign mem_we    = ((state_q == ST_HALT) && host_we_i) ||
                       ((state_q == ST_EXEC) && ex_st_we);
    assign mem_waddr = (state_q == ST_HALT) ? host_addr_i  : pi_q[ADDR_W-1:0];
    assign mem_wdata = (state_q == ST_HALT) ? host_wdata_i : acc_q;

    acc_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) store_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    acc_exec #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) exec_i (
        .op      (op_w),
        .operand (rd_data),
        .acc     (acc_q),
        .ci      (ci_q),
        .acc_nxt (acc_nxt),
        .ci_nxt  (ci_nxt),
        .st_we   (ex_st_we),
        .stop    (ex_stop)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (run_i || step_i) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC:  state_d = (ex_stop || step_mode_q) ? ST_HALT : ST_FETCH;
            default:  state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ci_q        <= '0;
            pi_q        <= '0;
            acc_q       <= '0;
            step_mode_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HALT: begin
                    if (run_i || step_i) step_mode_q <= !run_i;
                end
                ST_FETCH: begin
                    ci_q <= ci_inc;
                    pi_q <= rd_data;
                end
                ST_EXEC: begin
                    ci_q  <= ci_nxt;
                    acc_q <= acc_nxt;
                end
                default: ;
            endcase
        end
    end

    assign halted_o     = (state_q == ST_HALT);
    assign host_rdata_o = rd_data;
    assign ci_o         = ci_q;
    assign pi_o         = pi_q;
    assign acc_o        = acc_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_core_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input state_t            state,
    input op_t               op,
    input logic              step_mode,
    input logic [WORD_W-1:0] rd_data,
    input logic [ADDR_W-1:0] ci,
    input logic [WORD_W-1:0] acc,
    input logic              halted,
    input logic              run,
    input logic              step
);
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !run && !step) |=> ($stable(ci) && $stable(acc))); // R3

    AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (ci == ADDR_W'($past(ci) + 1'b1))); // R3

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && op == OP_STP) |=> (halted && ci == $past(ci))); // R10

    AST_SKIP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && op == OP_SKN && acc[WORD_W-1]) |=> (ci == ADDR_W'($past(ci) + 1'b1))); // R9

    AST_SUB_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && (op == OP_SUB || op == OP_SUBX)) |=> (acc == $past(acc) - $past(rd_data))); // R8

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && step_mode) |=> halted); // R11

endmodule

bind acc_core acc_core_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .op        (op_w),
    .step_mode (step_mode_q),
    .rd_data   (rd_data),
    .ci        (ci_q),
    .acc       (acc_q),
    .halted    (halted_o),
    .run       (run_i),
    .step      (step_i)
);

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        step_i = 1'b0;
    logic        halted_o;
    logic        host_we_i = 1'b0;
    logic [4:0]  host_addr_i = '0;
    logic [31:0] host_wdata_i = '0;
    logic [31:0] host_rdata_o;
    logic [4:0]  ci_o;
    logic [31:0] pi_o;
    logic [31:0] acc_o;

    int n_checks = 0;
    int n_errors = 0;

    localparam logic [31:0] IGN  = 32'hFFFF_1FE0;
    localparam logic [31:0] SENT = 32'h5E57_1E00;

    always #4 clk = ~clk;

    acc_core dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .step_i(step_i), .halted_o(halted_o),
        .host_we_i(host_we_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
        .host_rdata_o(host_rdata_o), .ci_o(ci_o), .pi_o(pi_o), .acc_o(acc_o)
    );

    function automatic logic [31:0] mk(input logic [2:0] op, input logic [4:0] n, input logic junk);
        return (junk ? IGN : 32'h0) | {16'h0, op, 8'h0, n};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic deposit(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we_i = 1'b1; host_addr_i = a; host_wdata_i = d;
        @(negedge clk);
        host_we_i = 1'b0;
    endtask

    task automatic examine(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr_i = a;
        #1 d = host_rdata_o;
    endtask

    task automatic wait_halt();
        int cyc = 0;
        @(negedge clk);
        while (!halted_o && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted_o) begin
            n_checks++; n_errors++;
            $display("FAIL R10 actual=running expected=halted");
        end
    endtask

    task automatic go(input logic as_step);
        @(negedge clk);
        if (as_step) step_i = 1'b1; else run_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0; run_i = 1'b0;
        while (!halted_o) @(negedge clk);
    endtask

    task automatic run_prog();
        @(negedge clk);
        run_i = 1'b1;
        @(negedge clk);
        run_i = 1'b0;
        wait_halt();
    endtask

    task automatic load_arith(input logic junk);
        deposit(5'd1, mk(3'd2, 5'd20, junk));
        deposit(5'd2, mk(3'd4, 5'd21, junk));
        deposit(5'd3, mk(3'd5, 5'd22, junk));
        deposit(5'd4, mk(3'd3, 5'd23, junk));
        deposit(5'd5, mk(3'd7, 5'd0,  junk));
        deposit(5'd6, mk(3'd0, 5'd30, junk));
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] x, y, z, v, ex;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 halted", {31'h0, halted_o}, 32'h1);
        chk("R1 ci", {27'h0, ci_o}, 32'h0);
        chk("R1 acc", acc_o, 32'h0);
        chk("R1 pi", pi_o, 32'h0);

        // R2: deposit then examine every word
        for (int a = 0; a < 32; a++) deposit(5'(a), (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F96);
        for (int a = 0; a < 32; a++) begin
            examine(5'(a), rd);
            chk("R2 examine", rd, (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F96);
        end

        deposit(5'd30, 32'hDEAD_BEE0);   // R5 target low bits 0
        deposit(5'd31, 32'h7777_7764);   // R5 target low bits 4

        // R3 R4 R7 R8 R5: subtraction chains, first from ci=0, later via jump at word 6
        for (int i = 0; i < 12; i++) begin
            case (i)
                0: begin x = 32'h0; y = 32'h0; z = 32'h0; end
                1: begin x = 32'h8000_0000; y = 32'h0; z = 32'h1; end
                2: begin x = 32'hFFFF_FFFF; y = 32'h1; z = 32'hFFFF_FFFF; end
                3: begin x = 32'h7FFF_FFFF; y = 32'h7FFF_FFFF; z = 32'h8000_0000; end
                default: begin
                    x = 32'(i) * 32'h9E37_79B9;
                    y = ~x + 32'(i);
                    z = 32'(i) << 29;
                end
            endcase
            load_arith(i[0]);
            deposit(5'd20, x); deposit(5'd21, y); deposit(5'd22, z);
            deposit(5'd23, SENT);
            run_prog();
            ex = 32'h0 - x - y - z;
            chk("R8 acc", acc_o, ex);
            examine(5'd23, rd);
            chk("R7 store", rd, ex);
            chk("R10 ci at stop", {27'h0, ci_o}, 32'd5);
            chk("R10 pi stop", pi_o, mk(3'd7, 5'd0, i[0]));
        end

        // R9: skip sweep across sign boundary
        for (int i = 0; i < 7; i++) begin
            case (i)
                0: v = 32'h0;
                1: v = 32'h1;
                2: v = 32'h7FFF_FFFF;
                3: v = 32'h8000_0000;
                4: v = 32'h8000_0001;
                5: v = 32'hFFFF_FFFF;
                default: v = 32'h0000_0100;
            endcase
            deposit(5'd1, mk(3'd2, 5'd20, 1'b0));
            deposit(5'd2, mk(3'd6, 5'd9,  i[0]));
            deposit(5'd3, mk(3'd0, 5'd31, 1'b0));
            deposit(5'd4, mk(3'd3, 5'd24, 1'b0));
            deposit(5'd20, v);
            deposit(5'd24, SENT);
            run_prog();
            ex = 32'h0 - v;
            examine(5'd24, rd);
            chk("R9 guarded store", rd, ex[31] ? ex : SENT);
            chk("R9 ci", {27'h0, ci_o}, 32'd5);
        end

        // R6: relative jump with upper garbage, words 2..4 must be skipped
        deposit(5'd1, mk(3'd1, 5'd25, 1'b1));
        deposit(5'd2, mk(3'd3, 5'd24, 1'b0));
        deposit(5'd3, mk(3'd3, 5'd24, 1'b0));
        deposit(5'd4, mk(3'd3, 5'd24, 1'b0));
        deposit(5'd25, 32'h5A00_0023);
        deposit(5'd24, SENT);
        run_prog();
        examine(5'd24, rd);
        chk("R6 skipped stores", rd, SENT);
        chk("R6 ci", {27'h0, ci_o}, 32'd5);

        // R11: single steps
        load_arith(1'b0);
        deposit(5'd20, 32'h0000_0009); deposit(5'd21, 32'h2); deposit(5'd22, 32'h3);
        go(1'b1);
        chk("R11 step1 ci", {27'h0, ci_o}, 32'd0);
        chk("R11 step1 pi", pi_o, mk(3'd0, 5'd30, 1'b0));
        go(1'b1);
        chk("R11 step2 ci", {27'h0, ci_o}, 32'd1);
        chk("R11 step2 acc", acc_o, 32'hFFFF_FFF7);
        go(1'b1);
        chk("R11 step3 acc", acc_o, 32'hFFFF_FFF5);

        // R2: host write during running is ignored
        deposit(5'd26, 32'h0000_600D);
        @(negedge clk);
        run_i = 1'b1;
        @(negedge clk);
        run_i = 1'b0;
        host_we_i = 1'b1; host_addr_i = 5'd26; host_wdata_i = 32'h0000_0BAD;
        @(negedge clk);
        host_we_i = 1'b0;
        wait_halt();
        examine(5'd26, rd);
        chk("R2 running write ignored", rd, 32'h0000_600D);
        chk("R8 final acc", acc_o, 32'hFFFF_FFF2);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule